// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two signed two's-complement operands of a configurable width. It uses radix-2 Booth recoding and runs one recoding step per clock. A one-cycle start request captures the multiplicand and the multiplier. The block then runs exactly WIDTH iteration cycles. Each cycle looks at the low multiplier bit together with a one-bit extension below it. From that bit pair it either adds the multiplicand to a running accumulator, subtracts it, or leaves the accumulator alone. It then shifts the accumulator, the multiplier and the extension bit right together as one arithmetic chain.

When the last step finishes, the block raises a one-cycle completion flag. At the same time it places the 2×WIDTH-bit signed product on a registered output. That output holds its value until the next multiplication completes. A start request that arrives while a multiplication is running is dropped. The accumulator carries one guard bit above the operand width. This lets the most negative multiplicand be negated without overflow.

Top module: `booth_seq_mult`

## Requirements
- R1: While reset is held, and after it is released with no start, `done` is 0 and `product` is all zeros.
- R2: A start request sampled high on a clock edge while idle is accepted. `done` is then high in the cycle after the WIDTH-th following rising edge, which is exactly WIDTH iteration steps later.
- R3: A step whose bit pair (multiplier bit 0, extension bit) is 1,0 adds the two's complement of the multiplicand (bitwise inverted plus one) to the accumulator.
- R4: A step whose bit pair is 0,1 adds the multiplicand to the accumulator.
- R5: A step whose bit pair is 0,0 or 1,1 leaves the accumulator unchanged and only shifts.
- R6: After the optional add, the chain {accumulator, multiplier, extension} shifts right by one as a unit, and the accumulator sign bit is copied into its top position.
- R7: `product` is the concatenation {accumulator low WIDTH bits, multiplier register}, read as a signed 2×WIDTH-bit value. For example, 3 × 7 with WIDTH=4 gives 8'h15.
- R8: `done` is high for exactly one cycle per accepted start.
- R9: Between completions, `product` keeps the last result stable.
- R10: A start request that arrives while a multiplication is in progress has no effect on the running operation and produces no extra result.
- R11: The most negative value times itself gives the correct positive result. With WIDTH=4, -8 × -8 gives 8'h40.
- R12: For every pair of WIDTH-bit signed operands, `product` equals their signed product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a multiplication |
| mcand | input | WIDTH | Signed multiplicand, captured on an accepted start |
| mplier | input | WIDTH | Signed multiplier, captured on an accepted start |
| done | output | 1 | One-cycle flag that marks a new result |
| product | output | 2*WIDTH | Signed product, held until the next completion |

## Verification
Every result is due a fixed time after its request. If the bench raises start before rising edge k, the result appears after edge k+WIDTH and is sampled on the falling edge that follows. For each request, the driver pushes the expected product onto a queue together with the cycle number at which it is due. The monitor samples on falling edges and pops an entry only when `done` is high. It checks both the value and the arrival cycle. If `done` rises with the queue empty, the monitor reports a stray completion, which covers both dropped start requests and pulses that last too long.

// File: rtl/booth_pkg.sv
// Shared definitions for the sequential Booth multiplier.
// Assumes nothing beyond IEEE 1800-2017 packages.
package booth_pkg;

    // Action chosen by one recoding step
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_ADD  = 2'd1,
        STEP_SUB  = 2'd2
    } step_op_e;

    // Controller phase
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Map a (current bit, extension bit) pair to a step action
    function automatic step_op_e pair_to_op(input logic cur, input logic ext);
        step_op_e op;
        case ({cur, ext})
            2'b10:   op = STEP_SUB;
            2'b01:   op = STEP_ADD;
            default: op = STEP_HOLD;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/booth_recode.sv
// Radix-2 recoder: turns the low multiplier bit and the extension bit into
// an add, subtract or hold decision. Purely combinational.
module booth_recode
    import booth_pkg::*;
(
    input  logic     cur_bit,
    input  logic     ext_bit,
    output step_op_e op
);

    // Decode the bit pair
    always_comb begin
        op = pair_to_op(cur_bit, ext_bit);
    end

endmodule

// File: rtl/booth_addsub.sv
// Ripple adder/subtractor for the accumulator. In subtract mode the operand
// is inverted and the carry-in set, which forms its two's complement. The
// final carry is discarded. Assumes both inputs are already the same width.
module booth_addsub
    import booth_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] acc_i,
    input  logic [AW-1:0] opnd_i,
    input  step_op_e      op,
    output logic [AW-1:0] sum_o
);

    logic [AW-1:0] b_sel;
    logic [AW-1:0] carry;

    // Choose the second operand and carry-in from the step action
    always_comb begin
        case (op)
            STEP_ADD: begin b_sel = opnd_i;      carry[0] = 1'b0; end
            STEP_SUB: begin b_sel = ~opnd_i;     carry[0] = 1'b1; end
            default:  begin b_sel = '0;          carry[0] = 1'b0; end
        endcase
    end

    // One full-adder cell per bit; the carry out of the top cell is dropped
    for (genvar i = 0; i < AW; i++) begin : g_fa
        assign sum_o[i] = acc_i[i] ^ b_sel[i] ^ carry[i];
        if (i < AW - 1) begin : g_cy
            assign carry[i+1] = (acc_i[i] & b_sel[i]) |
                                (acc_i[i] & carry[i]) |
                                (b_sel[i] & carry[i]);
        end
    end

endmodule

// File: rtl/booth_shift.sv
// Arithmetic right shift of the chain {accumulator, multiplier, extension}.
// The accumulator sign is replicated; the old multiplier LSB becomes the
// new extension bit. Combinational.
module booth_shift #(
    parameter int W  = 4,
    parameter int AW = W + 1
) (
    input  logic [AW-1:0] acc_i,
    input  logic [W-1:0]  mq_i,
    output logic [AW-1:0] acc_o,
    output logic [W-1:0]  mq_o,
    output logic          ext_o
);

    // Shift the chain right by one as a unit
    always_comb begin
        acc_o = {acc_i[AW-1], acc_i[AW-1:1]};
        mq_o  = {acc_i[0], mq_i[W-1:1]};
        ext_o = mq_i[0];
    end

endmodule

// File: rtl/booth_step_cnt.sv
// Down-counter of remaining recoding steps. Loaded with the operand width,
// decremented once per step; 'last' marks the final step.
module booth_step_cnt #(
    parameter int W  = 4,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          last
);

    // Load on accept, count down while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(W);
        end else if (dec && cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    // Flag the final step
    assign last = (cnt == CW'(1));

endmodule

// File: rtl/booth_seq_mult.sv
// Sequential signed Booth radix-2 multiplier.
// Accepts a start pulse while idle, runs WIDTH steps (one per clock), then
// pulses done and registers the 2*WIDTH-bit product. Start pulses during a
// run are ignored. Accumulator has one guard bit so -M never overflows.
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);

    localparam int AW = WIDTH + 1;
    localparam int CW = $clog2(WIDTH + 1);

    phase_e          phase_q;
    logic [AW-1:0]   acc_q;
    logic [WIDTH-1:0] mq_q;
    logic            ext_q;
    logic [AW-1:0]   mc_q;
    logic            done_q;
    logic [2*WIDTH-1:0] prod_q;

    logic            running;
    logic            accept;
    logic [CW-1:0]   cnt;
    logic            cnt_last;
    step_op_e        op;
    logic [AW-1:0]   acc_sum;
    logic [AW-1:0]   acc_nx;
    logic [WIDTH-1:0] mq_nx;
    logic            ext_nx;

    // Phase decode
    assign running = (phase_q == PH_RUN);
    assign accept  = (phase_q == PH_IDLE) && start;

    booth_recode u_recode (
        .cur_bit (mq_q[0]),
        .ext_bit (ext_q),
        .op      (op)
    );

    booth_addsub #(.AW(AW)) u_addsub (
        .acc_i  (acc_q),
        .opnd_i (mc_q),
        .op     (op),
        .sum_o  (acc_sum)
    );

    booth_shift #(.W(WIDTH), .AW(AW)) u_shift (
        .acc_i (acc_sum),
        .mq_i  (mq_q),
        .acc_o (acc_nx),
        .mq_o  (mq_nx),
        .ext_o (ext_nx)
    );

    booth_step_cnt #(.W(WIDTH), .CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .dec   (running),
        .cnt   (cnt),
        .last  (cnt_last)
    );

    // Datapath registers and control sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            acc_q   <= '0;
            mq_q    <= '0;
            ext_q   <= 1'b0;
            mc_q    <= '0;
            done_q  <= 1'b0;
            prod_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        acc_q   <= '0;
                        mq_q    <= mplier;
                        ext_q   <= 1'b0;
                        mc_q    <= {mcand[WIDTH-1], mcand};
                        phase_q <= PH_RUN;
                    end
                end
                default: begin
                    acc_q <= acc_nx;
                    mq_q  <= mq_nx;
                    ext_q <= ext_nx;
                    if (cnt_last) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                        prod_q  <= {acc_nx[WIDTH-1:0], mq_nx};
                    end
                end
            endcase
        end
    end

    // Outputs straight from registers
    assign done    = done_q;
    assign product = prod_q;

endmodule

// File: rtl/booth_seq_mult_chk.sv
// Protocol checker for booth_seq_mult, attached by bind below.
module booth_seq_mult_chk #(
    parameter int WIDTH = 4,
    parameter int CW    = $clog2(WIDTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               done,
    input logic [2*WIDTH-1:0] product,
    input logic               running,
    input logic [CW-1:0]      cnt,
    input logic [WIDTH:0]     mc_reg
);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(product));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start) |=> $stable(mc_reg));

    // R2
    step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(running) && $past(cnt) == CW'(1)));

    // R2
    run_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> cnt != '0);

endmodule

bind booth_seq_mult booth_seq_mult_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .product (product),
    .running (running),
    .cnt     (cnt),
    .mc_reg  (mc_q)
);

// File: tb/booth_seq_mult_tb.sv
// Scoreboard bench: driver queues expected results with due cycle, monitor
// pops and compares on each done.
module booth_seq_mult_tb;

    localparam int W  = 4;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  mcand = '0;
    logic [W-1:0]  mplier = '0;
    logic          done;
    logic [PW-1:0] product;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    logic [PW-1:0] exp_q[$];
    int            due_q[$];
    string         tag_q[$];
    logic [PW-1:0] last_prod = '0;

    booth_seq_mult #(.WIDTH(W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mcand   (mcand),
        .mplier  (mplier),
        .done    (done),
        .product (product)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor: compare each completion against the scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8/R10", "stray done", 1, 0);
            end else begin
                logic [PW-1:0] e;
                int d;
                string t;
                e = exp_q.pop_front();
                d = due_q.pop_front();
                t = tag_q.pop_front();
                check(product == e, t, "product", int'(product), int'(e));
                check(cyc == d, "R2", "done cycle", cyc, d);
                last_prod = e;
            end
        end
    end

    // Driver: one multiplication, optional start poke during the run
    task automatic run_mul(input int a, input int b, input string tag,
                           input bit poke);
        @(negedge clk);
        mcand  = W'(a);
        mplier = W'(b);
        start  = 1'b1;
        exp_q.push_back(PW'(a * b));
        due_q.push_back(cyc + W + 1);
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            mcand  = W'(a + 3);
            mplier = W'(b - 5);
            start  = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (W - 2) @(negedge clk);
        end else begin
            repeat (W) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs while reset is held
        check(done == 1'b0, "R1", "done in reset", int'(done), 0);
        check(product == '0, "R1", "product in reset", int'(product), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(done == 1'b0 && product == '0, "R1", "idle after reset",
              int'(product), 0);

        run_mul(3, 7, "R7", 1'b0);       // 3 x 7 = 8'h15
        run_mul(-8, -8, "R11", 1'b0);    // most negative squared
        run_mul(5, 5, "R3", 1'b0);       // pairs 10,01,10,01: subtract steps
        run_mul(-6, 5, "R4", 1'b0);      // add steps with negative multiplicand
        run_mul(7, 0, "R5", 1'b0);       // all pairs 00
        run_mul(6, -1, "R5", 1'b0);      // pairs 10 then 11
        run_mul(-3, 6, "R6", 1'b0);      // negative accumulator shifts
        run_mul(-7, 3, "R10", 1'b1);     // start poke while running

        // R9: product held after completion
        repeat (5) begin
            @(negedge clk);
            check(product == last_prod && !done, "R9", "hold",
                  int'(product), int'(last_prod));
        end

        // R12: every operand pair
        for (int a = -(1 << (W - 1)); a < (1 << (W - 1)); a++) begin
            for (int b = -(1 << (W - 1)); b < (1 << (W - 1)); b++) begin
                run_mul(a, b, "R12", 1'b0);
            end
        end

        repeat (W + 4) @(negedge clk);
        check(exp_q.size() == 0, "R2", "results outstanding",
              exp_q.size(), 0);
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule